// File: doc/BRIEF.md
# Charge and Discharge Accumulator and Timer Bank

This block keeps running totals for a battery monitor. On each update tick (nominally every 500 ms) it folds the latest conversion results into four 32-bit accumulators. It also advances four 32-bit elapsed-time counters, one paired with each accumulator. The pack current result is a sign/magnitude word. Its sign bit decides whether the magnitude goes into the charge total or the discharge total, and which of the two time counters advances. A temperature total takes the magnitude of either the internal or the external temperature result. A cell-2 voltage total takes the magnitude of the cell-2 result. Each of these two general totals has its own timer.

A master enable gates every update. The temperature and cell-2 totals also need their own enables. The host can read any of the eight counters through a select/data pair and can overwrite any counter with a single-cycle write strobe. The result inputs are level values sampled on the tick and the tick is a one-cycle pulse, so there is no valid/ready handshake and no back-pressure: a tick is always taken in the cycle it is high.

Top module: `accum_bank`

## Requirements
- R1: After reset all eight counters read zero.
- R2: On a tick with the master enable set and current sign bit (bit 15) equal to 0, the charge total (counter 0) grows by the 15-bit current magnitude and the charge timer (counter 4) grows by 1, while counters 1 and 5 are unchanged.
- R3: On a tick with the master enable set and current sign bit 1, the discharge total (counter 1) grows by the magnitude and the discharge timer (counter 5) grows by 1, while counters 0 and 4 are unchanged.
- R4: A zero magnitude is steered by its sign bit like any other value: the matching timer advances and the matching total is unchanged.
- R5: With master and temperature enables set, a tick adds to the temperature total (counter 2) the magnitude of the internal result when temp_sel is 0 and of the external result when temp_sel is 1; the sign bit of the temperature results is ignored.
- R6: With master and cell-2 enables set, a tick adds the cell-2 result magnitude (sign bit ignored) into counter 3.
- R7: The temperature timer (counter 6) and cell-2 timer (counter 7) advance by 1 on a tick only when their total is accumulating on that tick.
- R8: With the master enable clear, a tick changes no counter.
- R9: All counters are unsigned and wrap modulo 2^32.
- R10: A host write (wr_en high) loads wr_data into the counter chosen by wr_sel, overriding any tick update of that same counter in that cycle; the other counters update normally.
- R11: Without a tick and without a write, no counter changes.
- R12: Counter indices are 0 charge total, 1 discharge total, 2 temperature total, 3 cell-2 total, 4 charge timer, 5 discharge timer, 6 temperature timer, 7 cell-2 timer; rd_data shows the counter chosen by rd_sel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle update pulse |
| accum_en | input | 1 | Master accumulation enable |
| temp_acc_en | input | 1 | Temperature total enable |
| v2_acc_en | input | 1 | Cell-2 total enable |
| temp_sel | input | 1 | 0 internal, 1 external temperature source |
| cur_res | input | 16 | Current result, bit 15 sign, bits 14:0 magnitude |
| itemp_res | input | 16 | Internal temperature result (sign/magnitude) |
| etemp_res | input | 16 | External temperature result (sign/magnitude) |
| v2_res | input | 16 | Cell-2 voltage result (sign/magnitude) |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Counter index for the write |
| wr_data | input | 32 | Write value |
| rd_sel | input | 3 | Counter index for reading |
| rd_data | output | 32 | Selected counter value |

## Verification
A wrong steering decision or a stuck enable inside the bank shows up on the next tick. The sweep reads all eight counters after every tick, so a misrouted magnitude or a timer that advanced in the wrong lane appears within one update period. It also stays visible, because the totals never forget. A carry or wrap fault appears only when a total is near 2^32. Such a fault is therefore provoked directly by writing a value close to the top and ticking once.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned RES_W   = 16;
  localparam int unsigned N_LANE  = 4;
  localparam int unsigned SEL_W   = $clog2(2 * N_LANE);

  typedef enum logic [1:0] {
    LANE_CHG  = 2'd0,
    LANE_DIS  = 2'd1,
    LANE_TEMP = 2'd2,
    LANE_V2   = 2'd3
  } lane_e;
endpackage

// File: rtl/accum_steer.sv
module accum_steer
  import accum_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned RW = RES_W,
  parameter int unsigned NL = N_LANE
) (
  input  logic                accum_en,
  input  logic                temp_acc_en,
  input  logic                v2_acc_en,
  input  logic                temp_sel,
  input  logic [RW-1:0]       cur_res,
  input  logic [RW-1:0]       itemp_res,
  input  logic [RW-1:0]       etemp_res,
  input  logic [RW-1:0]       v2_res,
  output logic [NL-1:0]       lane_en,
  output logic [NL-1:0][CW-1:0] lane_add
);
  localparam int unsigned MW  = RW - 1;
  localparam int unsigned PAD = CW - MW;

  function automatic logic [CW-1:0] widen(input logic [RW-1:0] r);
    return {{PAD{1'b0}}, r[MW-1:0]};
  endfunction

  logic cur_neg;
  logic [RW-1:0] temp_pick;

  always_comb begin
    cur_neg   = cur_res[RW-1];
    temp_pick = temp_sel ? etemp_res : itemp_res;

    lane_en                  = '0;
    lane_en[int'(LANE_CHG)]  = accum_en & ~cur_neg;
    lane_en[int'(LANE_DIS)]  = accum_en &  cur_neg;
    lane_en[int'(LANE_TEMP)] = accum_en & temp_acc_en;
    lane_en[int'(LANE_V2)]   = accum_en & v2_acc_en;

    lane_add                  = '0;
    lane_add[int'(LANE_CHG)]  = widen(cur_res);
    lane_add[int'(LANE_DIS)]  = widen(cur_res);
    lane_add[int'(LANE_TEMP)] = widen(temp_pick);
    lane_add[int'(LANE_V2)]   = widen(v2_res);
  end
endmodule

// File: rtl/accum_lane.sv
module accum_lane #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic [W-1:0] addend,
  input  logic         wr_acc,
  input  logic         wr_tim,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] tim_q
);
  logic step;
  assign step = tick & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      tim_q <= '0;
    end else begin
      if (wr_acc)      acc_q <= wr_data;
      else if (step)   acc_q <= acc_q + addend;
      if (wr_tim)      tim_q <= wr_data;
      else if (step)   tim_q <= tim_q + W'(1);
    end
  end

  // R10: host write overrides the update
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> acc_q == $past(wr_data));

  // R2: total grows by the addend on an enabled tick, modulo 2^W (R9)
  a_r2_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !wr_acc) |=> acc_q == $past(acc_q) + $past(addend));

  // R7: timer advances by exactly one while accumulating
  a_r7_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !wr_tim) |=> tim_q == $past(tim_q) + W'(1));

  // R11: without a step or write the lane holds
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && en) && !wr_acc && !wr_tim) |=> ($stable(acc_q) && $stable(tim_q)));
endmodule

// File: rtl/accum_bank.sv
module accum_bank
  import accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             accum_en,
  input  logic             temp_acc_en,
  input  logic             v2_acc_en,
  input  logic             temp_sel,
  input  logic [RES_W-1:0] cur_res,
  input  logic [RES_W-1:0] itemp_res,
  input  logic [RES_W-1:0] etemp_res,
  input  logic [RES_W-1:0] v2_res,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  localparam int unsigned NREG = 2 * N_LANE;

  logic [N_LANE-1:0]            lane_en;
  logic [N_LANE-1:0][CNT_W-1:0] lane_add;
  logic [NREG-1:0][CNT_W-1:0]   regs;
  logic [NREG-1:0]              wr_hit;

  accum_steer #(.CW(CNT_W), .RW(RES_W), .NL(N_LANE)) u_steer (
    .accum_en    (accum_en),
    .temp_acc_en (temp_acc_en),
    .v2_acc_en   (v2_acc_en),
    .temp_sel    (temp_sel),
    .cur_res     (cur_res),
    .itemp_res   (itemp_res),
    .etemp_res   (etemp_res),
    .v2_res      (v2_res),
    .lane_en     (lane_en),
    .lane_add    (lane_add)
  );

  always_comb begin
    wr_hit = '0;
    if (wr_en) wr_hit[wr_sel] = 1'b1;
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    accum_lane #(.W(CNT_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .en      (lane_en[g]),
      .addend  (lane_add[g]),
      .wr_acc  (wr_hit[g]),
      .wr_tim  (wr_hit[g + N_LANE]),
      .wr_data (wr_data),
      .acc_q   (regs[g]),
      .tim_q   (regs[g + N_LANE])
    );
  end

  assign rd_data = regs[rd_sel];

  // R2/R3: a current tick steers into at most one of charge/discharge
  a_r3_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> !(regs[4] != $past(regs[4]) && regs[5] != $past(regs[5])));

  // R8: master disable freezes every counter
  a_r8_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !accum_en && !wr_en) |=> $stable(regs));
endmodule

// File: tb/tb_accum_bank.sv
`timescale 1ns/100ps
module tb_accum_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, accum_en = 1'b0, temp_acc_en = 1'b0, v2_acc_en = 1'b0, temp_sel = 1'b0;
  logic [15:0] cur_res = '0, itemp_res = '0, etemp_res = '0, v2_res = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m [8];
  bit done = 1'b0;

  always #2 clk = ~clk;

  accum_bank dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .accum_en(accum_en),
    .temp_acc_en(temp_acc_en), .v2_acc_en(v2_acc_en), .temp_sel(temp_sel),
    .cur_res(cur_res), .itemp_res(itemp_res), .etemp_res(etemp_res), .v2_res(v2_res),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #0.2;
      n_tests++;
      if (rd_data !== m[s]) begin
        n_fail++;
        $display("FAIL %s counter %0d actual %h expected %h", tag, s, rd_data, m[s]);
      end
    end
  endtask

  // one cycle of stimulus; model follows the requirements
  task automatic step(input bit t, input bit w, input logic [2:0] ws, input logic [31:0] wd);
    @(negedge clk);
    tick = t; wr_en = w; wr_sel = ws; wr_data = wd;
    if (t && accum_en) begin
      if (!cur_res[15]) begin m[0] += {17'd0, cur_res[14:0]}; m[4] += 1; end   // R2
      else              begin m[1] += {17'd0, cur_res[14:0]}; m[5] += 1; end   // R3
      if (temp_acc_en) begin                                                    // R5
        m[2] += {17'd0, temp_sel ? etemp_res[14:0] : itemp_res[14:0]};
        m[6] += 1;                                                              // R7
      end
      if (v2_acc_en) begin m[3] += {17'd0, v2_res[14:0]}; m[7] += 1; end        // R6
    end
    if (w) m[ws] = wd;                                                          // R10
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R12: write and read back each index
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(i), 32'h1000_0000 * (i + 1) + 32'(i * 7));
    check_all("R12 map");

    // R11: idle cycles change nothing
    cur_res = 16'h1234; accum_en = 1'b1;
    step(1'b0, 1'b0, 3'd0, 32'd0);
    step(1'b0, 1'b0, 3'd0, 32'd0);
    check_all("R11 idle");

    // sweep of enables, selects, sign and zero magnitude (R2 R3 R4 R5 R6 R7 R8)
    for (int c = 0; c < 64; c++) begin
      accum_en    = c[0];
      temp_sel    = c[1];
      temp_acc_en = c[2];
      v2_acc_en   = c[3];
      cur_res     = {c[4], c[5] ? 15'd0 : 15'((c * 517 + 3) & 16'h7fff)};
      itemp_res   = {c[1], 15'((c * 311 + 101) & 16'h7fff)};
      etemp_res   = {c[2], 15'((c * 977 + 29) & 16'h7fff)};
      v2_res      = {c[0], 15'((c * 1201 + 5) & 16'h7fff)};
      step(1'b1, 1'b0, 3'd0, 32'd0);
      if (!c[0])      check_all("R8 master off");
      else if (c[5])  check_all("R4 zero magnitude");
      else if (c[4])  check_all("R3 discharge");
      else            check_all("R2 R5 R6 R7 charge and general");
    end

    // R9: wrap of the charge total
    accum_en = 1'b1; temp_acc_en = 1'b0; v2_acc_en = 1'b0;
    step(1'b0, 1'b1, 3'd0, 32'hFFFF_FFF0);
    cur_res = 16'h0020;
    step(1'b1, 1'b0, 3'd0, 32'd0);
    check_all("R9 wrap");

    // R10: write coincides with a charge tick
    cur_res = 16'h0100;
    step(1'b1, 1'b1, 3'd0, 32'hA5A5_0000);
    check_all("R10 write priority acc");
    cur_res = 16'h8040; temp_acc_en = 1'b1;
    step(1'b1, 1'b1, 3'd5, 32'h0000_0777);
    check_all("R10 write priority timer");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule